// File: doc/BRIEF.md
# Isolated Digital I/O Register Window

This block is the eight-byte host register window of a card with sixteen isolated inputs and sixteen isolated output drivers. The host presents a three-bit byte offset together with a one-cycle read strobe or write strobe. The block returns input, filter and interrupt status bytes. It holds the two output driver bytes. It also keeps the control state for the input filters and for the change-of-state interrupt.

Several offsets act as commands. The type of access alone triggers the action, and the write data is ignored. One offset can mean one thing when read and another when written. For example, reading offset 2 turns interrupts on, and writing any value to offset 2 turns them off.

The inputs arrive already filtered. The filter circuits themselves are outside this block, which only drives their enable lines. While interrupts are enabled, any change on the inputs latches a pending flag. The request line is raised while that flag and the enable are both set.

Top module: `iso_io_window`

## Requirements
- R1: A write to offset 0 loads `drive[7:0]` and a write to offset 4 loads `drive[15:8]`. A read at either offset returns the byte last written there. Both bytes are 0 after reset.
- R2: A read at offset 1 returns `din[7:0]` and a read at offset 5 returns `din[15:8]`. Bit n of each byte is input n of that group.
- R3: A read at offset 2 enables interrupts and a write to offset 2 disables them. The read at offset 6 returns a status byte with bit 0 and bit 1 both equal to the enable.
- R4: When interrupts were enabled at a clock edge and `din` differs from its value at the previous edge, the pending flag is set. `irq` equals pending AND enable. Status bit 2 shows the pending flag.
- R5: Disabling interrupts keeps the pending flag. Only a write to offset 1 clears it. If an input change is seen at the same edge as that write, the flag stays set.
- R6: A read at offset 3 drives all sixteen `filt_en` lines to 1. A write to offset 3 clears the global enable and also clears the individual filter bits.
- R7: A write to offset 7 stores the individual filter bits for inputs 0-7. `filt_en[i]` is the global enable OR bit i, and lines 8-15 follow the global enable alone. A read at offset 7 returns `filt_en[7:0]`.
- R8: Writes to offsets 5 and 6 change nothing. Reads at offsets 2 and 3 return 0. Status bits 7..3 are always 0.
- R9: `rdata` is 0 while `rd_stb` is low. When both strobes are high in one cycle, only the write action takes place.
- R10: After reset, interrupts are disabled, nothing is pending, `irq` is 0 and all `filt_en` lines are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Byte offset within the window |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, valid while rd_stb is high |
| din | input | 16 | Filtered input levels, 1 = energized |
| drive | output | 16 | Output driver latches |
| filt_en | output | 16 | Per-input filter enable |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after it raises the read strobe on a falling edge, before any clock edge. Every side effect of a strobe is registered at the next rising edge. The bench therefore checks `drive`, `filt_en`, `irq` and the status byte from the following falling edge onward. An input change made on a falling edge is seen at the next rising edge and shows on `irq` straight after it. The same-edge case lines up the clear strobe and the input change on one falling edge, so both meet at the same rising edge.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned GROUPS = 2;
    localparam int unsigned IO_W   = BYTE_W * GROUPS;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned STAT_PAD = BYTE_W - 3;

    localparam logic [ADDR_W-1:0] OFF_DRV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_IN_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_IRQEN  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_FLTALL = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_DRV_HI = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_IN_HI  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_FLTSEL = 3'd7;

    typedef struct packed {
        logic [GROUPS-1:0] drv_wr;
        logic              irq_on;
        logic              irq_off;
        logic              irq_clr;
        logic              flt_on;
        logic              flt_off;
        logic              flt_sel;
    } act_t;

endpackage

// File: rtl/iso_io_decode.sv
module iso_io_decode
    import iso_io_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    output act_t              act
);

    logic rd_eff;

    always_comb begin
        rd_eff = rd_stb & ~wr_stb;
        act    = '0;
        act.drv_wr[0] = wr_stb && (addr == OFF_DRV_LO);
        act.drv_wr[1] = wr_stb && (addr == OFF_DRV_HI);
        act.irq_clr   = wr_stb && (addr == OFF_IN_LO);
        act.irq_off   = wr_stb && (addr == OFF_IRQEN);
        act.irq_on    = rd_eff && (addr == OFF_IRQEN);
        act.flt_off   = wr_stb && (addr == OFF_FLTALL);
        act.flt_on    = rd_eff && (addr == OFF_FLTALL);
        act.flt_sel   = wr_stb && (addr == OFF_FLTSEL);
    end

endmodule

// File: rtl/iso_io_outlatch.sv
module iso_io_outlatch #(
    parameter int unsigned BW = 8,
    parameter int unsigned NG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NG-1:0]    wr_grp,
    input  logic [BW-1:0]    wdata,
    output logic [NG*BW-1:0] drive
);

    localparam int unsigned W = NG * BW;

    typedef struct packed {
        logic [W-1:0] drv;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        for (int g = 0; g < int'(NG); g++) begin
            if (wr_grp[g]) lat_d.drv[g*BW +: BW] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign drive = lat_q.drv;

endmodule

// File: rtl/iso_io_filter.sv
module iso_io_filter #(
    parameter int unsigned FW = 16,
    parameter int unsigned MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flt_on,
    input  logic          flt_off,
    input  logic          flt_sel,
    input  logic [MW-1:0] wdata,
    output logic [FW-1:0] filt_en
);

    typedef struct packed {
        logic          glob;
        logic [MW-1:0] mask;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (flt_sel) flt_d.mask = wdata;
        if (flt_on)  flt_d.glob = 1'b1;
        if (flt_off) begin
            flt_d.glob = 1'b0;
            flt_d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    for (genvar i = 0; i < int'(FW); i++) begin : g_fen
        if (i < int'(MW)) begin : g_sel
            assign filt_en[i] = flt_q.glob | flt_q.mask[i];
        end else begin : g_glob
            assign filt_en[i] = flt_q.glob;
        end
    end

endmodule

// File: rtl/iso_io_irq.sv
module iso_io_irq #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         irq_on,
    input  logic         irq_off,
    input  logic         irq_clr,
    output logic         ien,
    output logic         pend,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         en;
        logic         pend;
    } irq_t;

    irq_t st_d, st_q;
    logic chg;

    always_comb begin
        chg        = |(din ^ st_q.prev);
        st_d       = st_q;
        st_d.prev  = din;
        if (irq_on)  st_d.en = 1'b1;
        if (irq_off) st_d.en = 1'b0;
        st_d.pend  = (st_q.pend & ~irq_clr) | (st_q.en & chg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien  = st_q.en;
    assign pend = st_q.pend;
    assign irq  = st_q.pend & st_q.en;

endmodule

// File: rtl/iso_io_window.sv
module iso_io_window
    import iso_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [IO_W-1:0]   din,
    output logic [IO_W-1:0]   drive,
    output logic [IO_W-1:0]   filt_en,
    output logic              irq
);

    act_t act;
    logic ien_w;
    logic pend_w;
    logic [BYTE_W-1:0] mux_d;

    iso_io_decode u_dec (
        .addr   (addr),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .act    (act)
    );

    iso_io_outlatch #(.BW(BYTE_W), .NG(GROUPS)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_grp (act.drv_wr),
        .wdata  (wdata),
        .drive  (drive)
    );

    iso_io_filter #(.FW(IO_W), .MW(BYTE_W)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .flt_on  (act.flt_on),
        .flt_off (act.flt_off),
        .flt_sel (act.flt_sel),
        .wdata   (wdata),
        .filt_en (filt_en)
    );

    iso_io_irq #(.W(IO_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .irq_on  (act.irq_on),
        .irq_off (act.irq_off),
        .irq_clr (act.irq_clr),
        .ien     (ien_w),
        .pend    (pend_w),
        .irq     (irq)
    );

    always_comb begin
        unique case (addr)
            OFF_DRV_LO: mux_d = drive[0 +: BYTE_W];
            OFF_IN_LO:  mux_d = din[0 +: BYTE_W];
            OFF_DRV_HI: mux_d = drive[BYTE_W +: BYTE_W];
            OFF_IN_HI:  mux_d = din[BYTE_W +: BYTE_W];
            OFF_STAT:   mux_d = {{STAT_PAD{1'b0}}, pend_w, ien_w, ien_w};
            OFF_FLTSEL: mux_d = filt_en[0 +: BYTE_W];
            default:    mux_d = '0;
        endcase
        rdata = rd_stb ? mux_d : '0;
    end

endmodule

// File: rtl/iso_io_window_chk.sv
module iso_io_window_chk
    import iso_io_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [BYTE_W-1:0] wdata,
    input logic [IO_W-1:0]   drive,
    input logic [IO_W-1:0]   filt_en,
    input logic              irq,
    input logic              ien,
    input logic              pend
);

    assert_drv_lo_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == OFF_DRV_LO) |=> drive[BYTE_W-1:0] == $past(wdata));

    assert_irq_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && addr == OFF_IRQEN) |=> ien);

    assert_irq_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == OFF_IRQEN) |=> !irq);

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(wr_stb && addr == OFF_IN_LO)) |=> pend);

    assert_flt_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == OFF_FLTALL) |=> filt_en == '0);

    assert_flt_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && addr == OFF_FLTALL) |=> &filt_en);

    assert_dead_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (addr == OFF_IN_HI || addr == OFF_STAT))
        |=> ($stable(drive) && $stable(filt_en) && $stable(ien)));

endmodule

bind iso_io_window iso_io_window_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .wdata   (wdata),
    .drive   (drive),
    .filt_en (filt_en),
    .irq     (irq),
    .ien     (ien_w),
    .pend    (pend_w)
);

// File: tb/sim_iso_io_window.sv
module sim_iso_io_window;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] din = '0;
    logic [15:0] drive;
    logic [15:0] filt_en;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_io_window u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wdata(wdata), .rdata(rdata), .din(din), .drive(drive),
        .filt_en(filt_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R10 drive", drive, 16'h0000);
        check("R10 filt_en", filt_en, 16'h0000);
        check("R10 irq", {15'b0, irq}, 16'h0000);
        rd(3'd6, d);
        check("R10 status", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_outputs();
        logic [7:0] d;
        wr(3'd0, 8'hA5);
        wr(3'd4, 8'h3C);
        check("R1 drive", drive, 16'h3CA5);
        rd(3'd0, d); check("R1 read lo", {8'h0, d}, 16'h00A5);
        rd(3'd4, d); check("R1 read hi", {8'h0, d}, 16'h003C);
    endtask

    task automatic t_inputs();
        logic [7:0] d;
        @(negedge clk); din = 16'h8421;
        rd(3'd1, d); check("R2 in lo", {8'h0, d}, 16'h0021);
        rd(3'd5, d); check("R2 in hi", {8'h0, d}, 16'h0084);
        rd(3'd6, d); check("R4 no pend while disabled", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        rd(3'd2, d); check("R8 read off2 data", {8'h0, d}, 16'h0000);
        rd(3'd6, d); check("R3 status enabled", {8'h0, d}, 16'h0003);
        check("R4 irq quiet", {15'b0, irq}, 16'h0000);
        @(negedge clk); din = 16'h8420;
        @(negedge clk);
        check("R4 irq after change", {15'b0, irq}, 16'h0001);
        rd(3'd6, d); check("R4 status pend", {8'h0, d}, 16'h0007);
        wr(3'd2, 8'hFF);
        check("R5 irq off after disable", {15'b0, irq}, 16'h0000);
        rd(3'd6, d); check("R5 pend kept", {8'h0, d}, 16'h0004);
        rd(3'd2, d);
        check("R5 irq back on enable", {15'b0, irq}, 16'h0001);
        wr(3'd1, 8'h00);
        check("R5 clear", {15'b0, irq}, 16'h0000);
        rd(3'd6, d); check("R5 status after clear", {8'h0, d}, 16'h0003);
        @(negedge clk);
        addr = 3'd1; wr_stb = 1'b1; din = 16'h0001;
        @(negedge clk);
        wr_stb = 1'b0;
        check("R5 clear with change keeps pend", {15'b0, irq}, 16'h0001);
        wr(3'd1, 8'h00);
        check("R5 clear again", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_dead();
        logic [7:0] d;
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        check("R8 drive unchanged", drive, 16'h3CA5);
        check("R8 filt unchanged", filt_en, 16'h0000);
        rd(3'd6, d); check("R8 status unchanged", {8'h0, d}, 16'h0003);
    endtask

    task automatic t_filter();
        logic [7:0] d;
        rd(3'd3, d); check("R8 read off3 data", {8'h0, d}, 16'h0000);
        check("R6 global on", filt_en, 16'hFFFF);
        wr(3'd7, 8'h55);
        check("R7 global dominates", filt_en, 16'hFFFF);
        rd(3'd7, d); check("R7 readback global", {8'h0, d}, 16'h00FF);
        wr(3'd3, 8'h12);
        check("R6 global off clears all", filt_en, 16'h0000);
        wr(3'd7, 8'hA6);
        check("R7 individual", filt_en, 16'h00A6);
        rd(3'd7, d); check("R7 readback", {8'h0, d}, 16'h00A6);
    endtask

    task automatic t_strobes();
        @(negedge clk);
        addr = 3'd0;
        #1 check("R9 rdata idle", {8'h0, rdata}, 16'h0000);
        @(negedge clk);
        addr = 3'd2; rd_stb = 1'b1; wr_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        #1;
        begin
            logic [7:0] d;
            rd(3'd6, d); check("R9 write wins", {8'h0, d}, 16'h0000);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_outputs();
        t_inputs();
        t_irq();
        t_dead();
        t_filter();
        t_strobes();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule